// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block decides which of five interrupt requests a small 8-bit CPU core services next. The sources are a non-maskable request, three restart requests that can be masked, and a general request line. The highest restart request is edge sensitive and is held in a latch. The middle and low restart requests and the general line are sampled as levels. The non-maskable request needs a rising edge, and the line must still be high when it is sampled. The block keeps a global interrupt-enable flag, which is set and cleared by explicit strobes, and a three-bit mask register for the restart sources.

The CPU pulses `boundary` for one cycle at each instruction boundary. At that edge the block picks the highest-priority eligible source and registers the result. For a vectored source it raises `pend_valid` with a fixed 16-bit service address on `vector`. For the general line it raises `gen_ack` and `hold_pc` instead, so that the core holds its program counter while an externally supplied restart or call instruction is inserted. The presentation stays in place until the CPU pulses `accept`. Acceptance drops the outputs, clears the global enable and consumes the latch of the source that was taken.

Top module: `vint_ctrl`

## Requirements
- R1: After reset, `pend_valid`, `gen_ack` and `hold_pc` are 0 and `vector` is 0. The global enable is cleared, all three mask bits are set (masked) and both request latches are empty.
- R2: At a `boundary` edge with nothing outstanding, the winner is chosen in this fixed order: non-maskable, then edge restart, then middle restart, then low restart, then general line.
- R3: The service addresses are 0x0024 for the non-maskable request, 0x003C for the edge restart, 0x0034 for the middle restart and 0x002C for the low restart.
- R4: The non-maskable request is taken whatever the values of the global enable and the mask bits.
- R5: The restart and general sources are eligible only while the global enable is 1. `ien_set` sets the enable and `ien_clr` clears it. When both strobes arrive in the same cycle, clear wins.
- R6: The mask register is written from `mask_wdata` when `mask_we` is high. Bit 2 masks the edge restart, bit 1 the middle restart and bit 0 the low restart, and a 1 means masked. The general line has no mask bit.
- R7: A 0-to-1 transition on `rq_edge` sets a latch that stays set after the input falls, until that source is accepted. An input held high after acceptance does not set the latch again.
- R8: `rq_mid`, `rq_low` and `gen_req` are not remembered. A source whose level is low at the `boundary` edge is not taken.
- R9: A rising edge on `nmi_req` is discarded if the line falls before the request is taken. Once the request is accepted, the line must fall and rise again before it can be taken a second time.
- R10: When the general line wins, `gen_ack` and `hold_pc` go to 1, while `pend_valid` stays 0 and `vector` stays 0.
- R11: The outputs change in the cycle after the `boundary` edge and hold their values until acceptance. A `boundary` strobe that arrives while a presentation is outstanding is ignored.
- R12: `accept` while a presentation is outstanding clears all outputs and the global enable at that edge. An `ien_set` in the same cycle is overridden.
- R13: A `boundary` strobe with no eligible source leaves all outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 1 | Non-maskable request, rising edge qualified by level |
| rq_edge | input | 1 | Highest restart request, edge latched |
| rq_mid | input | 1 | Middle restart request, level |
| rq_low | input | 1 | Lowest restart request, level |
| gen_req | input | 1 | General request line, level |
| ien_set | input | 1 | Set global interrupt enable |
| ien_clr | input | 1 | Clear global interrupt enable |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 3 | Mask value: bit 2 edge, bit 1 middle, bit 0 low; 1 masks |
| boundary | input | 1 | One-cycle instruction-boundary strobe |
| accept | input | 1 | CPU acceptance of the current presentation |
| pend_valid | output | 1 | A vectored source is being presented |
| vector | output | 16 | Service address of the presented source |
| gen_ack | output | 1 | Acknowledge for the general request line |
| hold_pc | output | 1 | Program-counter increment inhibit |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that `boundary` and `accept` are pulses, and that `accept` has meaning only while a presentation is outstanding. The bench drives all inputs on the falling edge and samples outputs on the next falling edge, so every request level is settled before the capturing edge. An edge request is always raised at least one edge before the strobe that is meant to see it. A near-exhaustive sweep covers all 32 request patterns against every mask value and both enable states. Directed sequences then cover latch persistence, discarded non-maskable pulses, strobes that arrive while a presentation is outstanding, and the ordering of simultaneous enable strobes.

// File: rtl/vint_pkg.sv
package vint_pkg;
  // Number of maskable restart sources; the first one is edge latched.
  localparam int NUM_RST  = 3;
  // Slot 0 is the non-maskable source, then restarts, then the general line.
  localparam int NUM_SRC  = NUM_RST + 2;
  localparam int IDX_NMI  = 0;
  localparam int IDX_EDGE = 1;
  localparam int IDX_GEN  = NUM_SRC - 1;
endpackage

// File: rtl/vint_edge.sv
module vint_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  // Previous sample resets high so a line held high through reset is no edge.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/vint_state.sv
module vint_state
  import vint_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               nmi_lvl,
  input  logic               nmi_rise,
  input  logic               edge_rise,
  input  logic               ien_set,
  input  logic               ien_clr,
  input  logic               mask_we,
  input  logic [NUM_RST-1:0] mask_wdata,
  input  logic               take,
  input  logic               take_nmi,
  input  logic               take_edge,
  output logic               ien_q,
  output logic [NUM_RST-1:0] mask_q,
  output logic               nmi_lat_q,
  output logic               edge_lat_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q      <= 1'b0;
      mask_q     <= '1;
      nmi_lat_q  <= 1'b0;
      edge_lat_q <= 1'b0;
    end else begin
      // Acceptance dominates, then clear, then set.
      if (take)         ien_q <= 1'b0;
      else if (ien_clr) ien_q <= 1'b0;
      else if (ien_set) ien_q <= 1'b1;

      if (mask_we) mask_q <= mask_wdata;

      // A fresh edge in the accept cycle stays recorded.
      if (edge_rise)                edge_lat_q <= 1'b1;
      else if (take && take_edge)   edge_lat_q <= 1'b0;

      if (take && take_nmi)         nmi_lat_q <= 1'b0;
      else if (nmi_rise)            nmi_lat_q <= 1'b1;
      else if (!nmi_lvl)            nmi_lat_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vint_prio.sv
module vint_prio #(
  parameter int N = 5
) (
  input  logic [N-1:0] cand,
  output logic [N-1:0] grant,
  output logic         any
);
  // Index 0 is the highest priority; scanning downward lets it win.
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  assign any = |cand;
endmodule

// File: rtl/vint_present.sv
module vint_present
  import vint_pkg::*;
#(
  parameter int                              VEC_W   = 16,
  parameter logic [NUM_SRC-1:0][VEC_W-1:0]   VEC_TBL = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               boundary,
  input  logic               accept,
  input  logic               win_any,
  input  logic [NUM_SRC-1:0] win_oh,
  output logic               pend_valid,
  output logic [VEC_W-1:0]   vector,
  output logic               gen_ack,
  output logic               hold_pc,
  output logic               take,
  output logic               take_nmi,
  output logic               take_edge
);
  logic               busy;
  logic [NUM_SRC-1:0] cur_q;
  logic [VEC_W-1:0]   vterm [NUM_SRC];
  logic [VEC_W-1:0]   vec_sel;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_vterm
    assign vterm[g] = win_oh[g] ? VEC_TBL[g] : '0;
  end

  always_comb begin
    vec_sel = '0;
    for (int i = 0; i < NUM_SRC; i++) vec_sel |= vterm[i];
  end

  assign busy      = pend_valid | gen_ack;
  assign take      = accept & busy;
  assign take_nmi  = cur_q[IDX_NMI];
  assign take_edge = cur_q[IDX_EDGE];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      gen_ack    <= 1'b0;
      hold_pc    <= 1'b0;
      vector     <= '0;
      cur_q      <= '0;
    end else if (take) begin
      pend_valid <= 1'b0;
      gen_ack    <= 1'b0;
      hold_pc    <= 1'b0;
      vector     <= '0;
      cur_q      <= '0;
    end else if (boundary && !busy && win_any) begin
      cur_q <= win_oh;
      if (win_oh[IDX_GEN]) begin
        gen_ack <= 1'b1;
        hold_pc <= 1'b1;
      end else begin
        pend_valid <= 1'b1;
        vector     <= vec_sel;
      end
    end
  end
endmodule

// File: rtl/vint_ctrl.sv
module vint_ctrl
  import vint_pkg::*;
#(
  parameter int               VEC_W    = 16,
  parameter logic [VEC_W-1:0] VEC_NMI  = 16'h0024,
  parameter logic [VEC_W-1:0] VEC_EDGE = 16'h003C,
  parameter logic [VEC_W-1:0] VEC_MID  = 16'h0034,
  parameter logic [VEC_W-1:0] VEC_LOW  = 16'h002C
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               nmi_req,
  input  logic               rq_edge,
  input  logic               rq_mid,
  input  logic               rq_low,
  input  logic               gen_req,
  input  logic               ien_set,
  input  logic               ien_clr,
  input  logic               mask_we,
  input  logic [NUM_RST-1:0] mask_wdata,
  input  logic               boundary,
  input  logic               accept,
  output logic               pend_valid,
  output logic [VEC_W-1:0]   vector,
  output logic               gen_ack,
  output logic               hold_pc
);
  localparam logic [NUM_SRC-1:0][VEC_W-1:0] VEC_TBL =
    {{VEC_W{1'b0}}, VEC_LOW, VEC_MID, VEC_EDGE, VEC_NMI};

  logic [1:0]         rise;
  logic               ien_q;
  logic [NUM_RST-1:0] mask_q;
  logic               nmi_lat_q;
  logic               edge_lat_q;
  logic               take, take_nmi, take_edge;
  logic [NUM_RST-1:0] rst_src;
  logic [NUM_SRC-1:0] cand;
  logic [NUM_SRC-1:0] win_oh;
  logic               win_any;

  vint_edge #(.W(2)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  ({rq_edge, nmi_req}),
    .rise (rise)
  );

  vint_state u_state (
    .clk        (clk),
    .rst        (rst),
    .nmi_lvl    (nmi_req),
    .nmi_rise   (rise[0]),
    .edge_rise  (rise[1]),
    .ien_set    (ien_set),
    .ien_clr    (ien_clr),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .take       (take),
    .take_nmi   (take_nmi),
    .take_edge  (take_edge),
    .ien_q      (ien_q),
    .mask_q     (mask_q),
    .nmi_lat_q  (nmi_lat_q),
    .edge_lat_q (edge_lat_q)
  );

  // Restart slot j sits at priority j+1; its mask bit counts down from the top.
  assign rst_src = {rq_low, rq_mid, edge_lat_q};

  assign cand[IDX_NMI] = nmi_lat_q & nmi_req;
  for (genvar j = 0; j < NUM_RST; j++) begin : g_rst
    assign cand[IDX_EDGE + j] = ien_q & rst_src[j] & ~mask_q[NUM_RST-1-j];
  end
  assign cand[IDX_GEN] = ien_q & gen_req;

  vint_prio #(.N(NUM_SRC)) u_prio (
    .cand  (cand),
    .grant (win_oh),
    .any   (win_any)
  );

  vint_present #(.VEC_W(VEC_W), .VEC_TBL(VEC_TBL)) u_present (
    .clk        (clk),
    .rst        (rst),
    .boundary   (boundary),
    .accept     (accept),
    .win_any    (win_any),
    .win_oh     (win_oh),
    .pend_valid (pend_valid),
    .vector     (vector),
    .gen_ack    (gen_ack),
    .hold_pc    (hold_pc),
    .take       (take),
    .take_nmi   (take_nmi),
    .take_edge  (take_edge)
  );
endmodule

// File: rtl/vint_ctrl_chk.sv
module vint_ctrl_chk #(
  parameter int VEC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             boundary,
  input logic             accept,
  input logic             pend_valid,
  input logic [VEC_W-1:0] vector,
  input logic             gen_ack,
  input logic             hold_pc,
  input logic             ien
);
  // R10: general acknowledge never overlaps a vectored presentation
  a_r10_excl: assert property (@(posedge clk) disable iff (rst)
    gen_ack |-> !pend_valid && hold_pc && (vector == '0));

  // R3: a presented address is always one of the fixed service addresses
  a_r3_vec_legal: assert property (@(posedge clk) disable iff (rst)
    pend_valid |-> (vector == VEC_W'(16'h0024)) || (vector == VEC_W'(16'h003C)) ||
                   (vector == VEC_W'(16'h0034)) || (vector == VEC_W'(16'h002C)));

  // R11: a presentation holds until accepted
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (pend_valid && !accept) |=> pend_valid && $stable(vector));

  // R11: nothing appears without a boundary strobe
  a_r11_no_spont: assert property (@(posedge clk) disable iff (rst)
    (!pend_valid && !gen_ack && !boundary) |=> !pend_valid && !gen_ack);

  // R12: acceptance clears outputs and the global enable
  a_r12_accept_clears: assert property (@(posedge clk) disable iff (rst)
    (accept && (pend_valid || gen_ack)) |=> !pend_valid && !gen_ack && !hold_pc && !ien);

  // R5: the general line cannot be acknowledged while disabled
  a_r5_gen_needs_ien: assert property (@(posedge clk) disable iff (rst)
    (!ien && !gen_ack) |=> !gen_ack);
endmodule

bind vint_ctrl vint_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .boundary   (boundary),
  .accept     (accept),
  .pend_valid (pend_valid),
  .vector     (vector),
  .gen_ack    (gen_ack),
  .hold_pc    (hold_pc),
  .ien        (ien_q)
);

// File: tb/vint_ctrl_tb.sv
`timescale 1ns/1ps
module vint_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nmi_req = 0, rq_edge = 0, rq_mid = 0, rq_low = 0, gen_req = 0;
  logic        ien_set = 0, ien_clr = 0, mask_we = 0;
  logic [2:0]  mask_wdata = 0;
  logic        boundary = 0, accept = 0;
  logic        pend_valid, gen_ack, hold_pc;
  logic [15:0] vector;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  vint_ctrl u_dut (
    .clk(clk), .rst(rst), .nmi_req(nmi_req), .rq_edge(rq_edge), .rq_mid(rq_mid),
    .rq_low(rq_low), .gen_req(gen_req), .ien_set(ien_set), .ien_clr(ien_clr),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .boundary(boundary), .accept(accept),
    .pend_valid(pend_valid), .vector(vector), .gen_ack(gen_ack), .hold_pc(hold_pc)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_out(input string tag, input logic pv, input logic [15:0] v,
                            input logic ga);
    chk({tag, " pend_valid"}, 32'(pend_valid), 32'(pv));
    chk({tag, " vector"},     32'(vector),     32'(v));
    chk({tag, " gen_ack"},    32'(gen_ack),    32'(ga));
    chk({tag, " hold_pc"},    32'(hold_pc),    32'(ga));
  endtask

  task automatic do_reset();
    {nmi_req, rq_edge, rq_mid, rq_low, gen_req} = '0;
    {ien_set, ien_clr, mask_we, boundary, accept} = '0;
    rst = 1'b1; cyc(); cyc(); rst = 1'b0; cyc();
  endtask

  task automatic set_mask(input logic [2:0] m);
    mask_we = 1'b1; mask_wdata = m; cyc(); mask_we = 1'b0;
  endtask

  task automatic en_on();
    ien_set = 1'b1; cyc(); ien_set = 1'b0;
  endtask

  task automatic strobe();
    boundary = 1'b1; cyc(); boundary = 1'b0;
  endtask

  task automatic take_it();
    accept = 1'b1; cyc(); accept = 1'b0;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state, masks set, enable clear
    do_reset();
    expect_out("R1 reset", 0, 16'h0000, 0);
    rq_mid = 1; rq_low = 1; en_on(); strobe();
    expect_out("R1 masks reset masked", 0, 16'h0000, 0);
    rq_mid = 0; rq_low = 0;

    // R5: enable needed; simultaneous set and clear leaves it clear
    do_reset(); set_mask(3'b000); rq_mid = 1; strobe();
    expect_out("R5 disabled", 0, 16'h0000, 0);
    ien_set = 1; ien_clr = 1; cyc(); ien_set = 0; ien_clr = 0; strobe();
    expect_out("R5 clear wins", 0, 16'h0000, 0);
    en_on(); strobe();
    expect_out("R5 enabled", 1, 16'h0034, 0);

    // R12: accept clears; ien_set in the accept cycle is overridden
    ien_set = 1; take_it(); ien_set = 0;
    expect_out("R12 cleared", 0, 16'h0000, 0);
    strobe();
    expect_out("R12 enable dropped", 0, 16'h0000, 0);
    rq_mid = 0;

    // R7: edge latch survives the input falling
    do_reset(); set_mask(3'b000); en_on();
    rq_edge = 1; cyc(); rq_edge = 0; cyc(); cyc(); strobe();
    expect_out("R7 latched", 1, 16'h003C, 0);
    take_it(); en_on(); strobe();
    expect_out("R7 consumed", 0, 16'h0000, 0);
    rq_edge = 1; cyc(); strobe();
    expect_out("R7 new edge", 1, 16'h003C, 0);
    take_it(); en_on(); strobe();
    expect_out("R7 held high no retrigger", 0, 16'h0000, 0);
    rq_edge = 0;

    // R8: level source low at the strobe is not taken
    do_reset(); set_mask(3'b000); en_on();
    rq_low = 1; cyc(); rq_low = 0; gen_req = 1; cyc(); gen_req = 0; strobe();
    expect_out("R8 level forgotten", 0, 16'h0000, 0);

    // R9 and R4: non-maskable pulse dropped, then taken with everything disabled
    do_reset();
    nmi_req = 1; cyc(); nmi_req = 0; cyc(); strobe();
    expect_out("R9 dropped pulse", 0, 16'h0000, 0);
    nmi_req = 1; cyc(); strobe();
    expect_out("R4 ignores enable and mask", 1, 16'h0024, 0);
    take_it(); strobe();
    expect_out("R9 no second take", 0, 16'h0000, 0);
    nmi_req = 0;

    // R11: strobe during an outstanding presentation is ignored
    do_reset(); set_mask(3'b000); en_on(); rq_mid = 1; strobe();
    expect_out("R11 first", 1, 16'h0034, 0);
    nmi_req = 1; cyc(); strobe(); cyc();
    expect_out("R11 held", 1, 16'h0034, 0);
    take_it(); strobe();
    expect_out("R11 after accept", 1, 16'h0024, 0);
    take_it(); nmi_req = 0; rq_mid = 0;

    // R13: no eligible source
    do_reset(); en_on(); strobe();
    expect_out("R13 none", 0, 16'h0000, 0);

    // R2 R3 R4 R6 R10: sweep of request patterns, masks and enable
    for (int m = 0; m < 8; m++) begin
      for (int en = 0; en < 2; en++) begin
        for (int r = 0; r < 32; r++) begin
          logic        e_pv, e_ga;
          logic [15:0] e_v;
          string       tag;
          do_reset();
          set_mask(3'(m));
          if (en != 0) en_on();
          nmi_req = r[0]; rq_edge = r[1]; rq_mid = r[2]; rq_low = r[3]; gen_req = r[4];
          cyc();
          strobe();
          e_pv = 0; e_ga = 0; e_v = 16'h0000; tag = "R13 sweep none";
          if (r[0]) begin
            e_pv = 1; e_v = 16'h0024; tag = "R4 R2 sweep nmi";
          end else if (en != 0) begin
            if (r[1] && !m[2]) begin
              e_pv = 1; e_v = 16'h003C; tag = "R2 R3 R6 sweep edge";
            end else if (r[2] && !m[1]) begin
              e_pv = 1; e_v = 16'h0034; tag = "R2 R3 R6 sweep mid";
            end else if (r[3] && !m[0]) begin
              e_pv = 1; e_v = 16'h002C; tag = "R2 R3 R6 sweep low";
            end else if (r[4]) begin
              e_ga = 1; tag = "R10 sweep general";
            end
          end
          expect_out(tag, e_pv, e_v, e_ga);
          take_it();
          expect_out("R12 sweep cleared", 0, 16'h0000, 0);
          {nmi_req, rq_edge, rq_mid, rq_low, gen_req} = '0;
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule